// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Every register specifier that reaches it is logical. Before any access, the specifier is shifted by a rotating base offset, and the sum wraps at the file size. Once per loop iteration, the branch that closes the loop pulses a strobe that lowers the base by one. A value written under logical index k in one iteration is therefore found under index k+1 in the next iteration. Each iteration's copy of a loop variable lives in its own physical register, so no renaming hardware is needed.

The block has two combinational read ports and one synchronous write port, and all three take logical indices. The base register can also be loaded synchronously with any value before a loop starts. A load takes priority over a decrement in the same cycle. Every read, write and base update in a given cycle uses the base value that held at the start of that cycle.

Top module: `rot_regfile`

## Requirements
- R1: Each read or write with logical index i uses physical register (i + base) mod NREGS. NREGS defaults to 64.
- R2: Each cycle with `base_dec` high and `base_load` low lowers the base by one. A base of 0 wraps to NREGS-1 (63).
- R3: With base 7, logical index 13 reaches physical register 20. After one decrement, the same index reaches physical register 19.
- R4: Writes to one logical index in two consecutive iterations (a decrement between them) land in different physical registers.
- R5: A value written under logical index k before a decrement reads back under logical index k+1 after it.
- R6: `base_load` sets the base to `base_load_val` on the next edge and wins over `base_dec`.
- R7: A write or read made in the same cycle as a decrement uses the base from before that decrement.
- R8: Reset (active-low `rst_n`) clears the base to 0 and every register to 0.
- R9: Reads are combinational. A write takes effect at the next edge, so a read of the same register in the write cycle returns the old value. With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_idx | input | IDX_W | Logical index, read port 0 |
| rd0_data | output | DATA_W | Read data, port 0 |
| rd1_idx | input | IDX_W | Logical index, read port 1 |
| rd1_data | output | DATA_W | Read data, port 1 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W | Logical index, write port |
| wr_data | input | DATA_W | Write data |
| base_dec | input | 1 | Iteration strobe: lower the base by one |
| base_load | input | 1 | Load the base with `base_load_val` |
| base_load_val | input | IDX_W | Value to load into the base |
| rot_base | output | IDX_W | Current rotating base |

## Verification
Read data follows its index and the current base with zero cycles of delay. The bench therefore samples read data one nanosecond after it drives the inputs, in the same cycle. A write, a decrement or a load shows up one edge later. The bench samples those effects one nanosecond after that edge, and by then the next inputs have not yet been applied. The bench never looks inside the design to see where a write landed. Instead, it reloads the base with 0 so that logical indices equal physical ones, and reads the target register back through a normal read port.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    typedef enum logic [1:0] {
        BOP_HOLD = 2'd0,
        BOP_DEC  = 2'd1,
        BOP_LOAD = 2'd2
    } base_op_e;

    // A load wins over a decrement issued in the same cycle.
    function automatic base_op_e decode_base_op(input logic dec, input logic load);
        if (load)
            return BOP_LOAD;
        else if (dec)
            return BOP_DEC;
        return BOP_HOLD;
    endfunction

endpackage

// File: rtl/rrf_base.sv
module rrf_base #(
    parameter int NREGS = 64,
    parameter int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] base_q
);
    import rrf_pkg::*;

    localparam logic [IDX_W-1:0] TOP = IDX_W'(NREGS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] base;
    } base_st_t;

    base_st_t st_d, st_q;
    base_op_e op;

    always_comb begin
        op   = decode_base_op(dec, load);
        st_d = st_q;
        case (op)
            BOP_LOAD: st_d.base = load_val;
            BOP_DEC:  st_d.base = (st_q.base == '0) ? TOP : st_q.base - 1'b1;
            default:  st_d.base = st_q.base;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign base_q = st_q.base;

    AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (base_q == (($past(base_q) == '0) ? TOP : $past(base_q) - 1'b1))); // R2
    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (base_q == $past(load_val))); // R6
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(base_q)); // R2

endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
    parameter int NREGS = 64,
    parameter int IDX_W = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] phys
);
    localparam int SUM_W = IDX_W + 1;

    generate
        if ((1 << IDX_W) == NREGS) begin : g_pow2
            // The modulo comes free from truncation.
            assign phys = idx + base;
        end else begin : g_generic
            logic [SUM_W-1:0] sum;
            always_comb begin
                sum = SUM_W'(idx) + SUM_W'(base);
                if (sum >= SUM_W'(NREGS))
                    sum = sum - SUM_W'(NREGS);
            end
            assign phys = sum[IDX_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 64,
    parameter int NRD    = 2,
    parameter int IDX_W  = $clog2(NREGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NRD-1:0][IDX_W-1:0]    rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
    logic [DATA_W-1:0] mem_d [NREGS];
    logic [DATA_W-1:0] mem_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++)
            mem_d[i] = mem_q[i];
        if (wr_en)
            mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++)
                mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++)
                mem_q[i] <= mem_d[i];
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            assign rd_data[p] = mem_q[rd_addr[p]];
        end
    endgenerate

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R9

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 64,
    parameter int IDX_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              base_dec,
    input  logic              base_load,
    input  logic [IDX_W-1:0]  base_load_val,
    output logic [IDX_W-1:0]  rot_base
);
    localparam int NRD = 2;

    logic [IDX_W-1:0]                base_q;
    logic [NRD-1:0][IDX_W-1:0]       rd_log;
    logic [NRD-1:0][IDX_W-1:0]       rd_phys;
    logic [NRD-1:0][DATA_W-1:0]      rd_val;
    logic [IDX_W-1:0]                wr_phys;

    rrf_base #(.NREGS(NREGS), .IDX_W(IDX_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (base_dec),
        .load     (base_load),
        .load_val (base_load_val),
        .base_q   (base_q)
    );

    assign rd_log[0] = rd0_idx;
    assign rd_log[1] = rd1_idx;

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rmap
            rrf_map #(.NREGS(NREGS), .IDX_W(IDX_W)) u_map (
                .idx  (rd_log[p]),
                .base (base_q),
                .phys (rd_phys[p])
            );
        end
    endgenerate

    rrf_map #(.NREGS(NREGS), .IDX_W(IDX_W)) u_wmap (
        .idx  (wr_idx),
        .base (base_q),
        .phys (wr_phys)
    );

    rrf_store #(.DATA_W(DATA_W), .NREGS(NREGS), .NRD(NRD), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_phys),
        .wr_data (wr_data),
        .rd_addr (rd_phys),
        .rd_data (rd_val)
    );

    assign rd0_data = rd_val[0];
    assign rd1_data = rd_val[1];
    assign rot_base = base_q;

    AST_ITER_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (base_dec && !base_load) |=> ((wr_idx != $past(wr_idx)) || (wr_phys != $past(wr_phys)))); // R4

endmodule

// File: tb/rot_regfile_tb.sv
module rot_regfile_tb;
    localparam int DW = 32;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0, base_load_val = '0;
    logic [DW-1:0] rd0_data, rd1_data, wr_data = '0;
    logic          wr_en = 1'b0, base_dec = 1'b0, base_load = 1'b0;
    logic [IW-1:0] rot_base;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rot_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .base_dec(base_dec), .base_load(base_load), .base_load_val(base_load_val),
        .rot_base(rot_base)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Advance one edge; stimulus for the next cycle follows 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 0; base_dec = 0; base_load = 0;
    endtask

    task automatic set_base(input logic [IW-1:0] v);
        base_load = 1; base_load_val = v;
        tick();
    endtask

    task automatic wr(input logic [IW-1:0] idx, input logic [DW-1:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        tick();
    endtask

    task automatic rd_phys(input string req, input logic [IW-1:0] p, input logic [DW-1:0] exp);
        set_base(6'd0);
        rd0_idx = p; #1;
        chk(req, rd0_data, exp);
    endtask

    task automatic t_reset();
        chk("R8 base", 32'(rot_base), 32'd0);
        rd0_idx = 0; rd1_idx = 63; #1;
        chk("R8 reg0", rd0_data, 0);
        chk("R8 reg63", rd1_data, 0);
    endtask

    task automatic t_example();
        set_base(6'd7);
        chk("R6 load", 32'(rot_base), 32'd7);
        wr(6'd13, 32'hA13);
        rd1_idx = 13; #1;
        chk("R1 same base", rd1_data, 32'hA13);
        rd_phys("R3 phys20", 6'd20, 32'hA13);
        set_base(6'd7);
        base_dec = 1; tick();
        chk("R2 dec", 32'(rot_base), 32'd6);
        wr(6'd13, 32'hB13);
        rd_phys("R3 phys19", 6'd19, 32'hB13);
        rd0_idx = 20; #1;
        chk("R4 old kept", rd0_data, 32'hA13);
    endtask

    task automatic t_wrap();
        set_base(6'd0);
        base_dec = 1; tick();
        chk("R2 wrap", 32'(rot_base), 32'd63);
        wr(6'd5, 32'h55);
        rd_phys("R1 wrap addr", 6'd4, 32'h55);
    endtask

    task automatic t_rotate();
        set_base(6'd40);
        for (int i = 0; i < 4; i++) begin
            wr(6'd2, 32'h100 + i);
            base_dec = 1; tick();
            rd1_idx = 3; #1;
            chk("R5 k+1", rd1_data, 32'h100 + i);
        end
        for (int i = 0; i < 4; i++)
            rd_phys("R4 distinct", 6'(42 - i), 32'h100 + i);
    endtask

    task automatic t_samecycle();
        set_base(6'd20);
        wr(6'd0, 32'h777);
        wr_en = 1; wr_idx = 1; wr_data = 32'h888; base_dec = 1;
        rd0_idx = 0; #1;
        chk("R7 read pre-dec", rd0_data, 32'h777);
        tick();
        chk("R7 base", 32'(rot_base), 32'd19);
        rd_phys("R7 write pre-dec", 6'd21, 32'h888);
        rd0_idx = 20; #1;
        chk("R7 neighbour", rd0_data, 32'h777);
    endtask

    task automatic t_loadprio();
        set_base(6'd9);
        base_load = 1; base_load_val = 40; base_dec = 1;
        tick();
        chk("R6 priority", 32'(rot_base), 32'd40);
        tick();
        chk("R6 hold", 32'(rot_base), 32'd40);
    endtask

    task automatic t_rdwr();
        set_base(6'd0);
        wr(6'd30, 32'h1111);
        wr_en = 1; wr_idx = 30; wr_data = 32'h2222;
        rd0_idx = 30; #1;
        chk("R9 old in write cycle", rd0_data, 32'h1111);
        tick();
        chk("R9 new after edge", rd0_data, 32'h2222);
        wr_en = 0; wr_idx = 30; wr_data = 32'h3333;
        tick();
        chk("R9 no write when disabled", rd0_data, 32'h2222);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #20 rst_n = 1'b1;
        tick();
        t_reset();
        t_example();
        t_wrap();
        t_rotate();
        t_samecycle();
        t_loadprio();
        t_rdwr();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule